// File: doc/BRIEF.md
# Write-Status Polling Responder

This block produces the byte that a host sees when it reads the memory device while an internal write or erase may still be running. It gives the host two independent ways to tell when the operation has finished. The first is the inverted-MSB poll: while the write engine reports busy, the polled bit is returned as the inverse of the matching bit of the byte that was loaded last, and it reads true once the array holds that byte. The second is the alternating-bit poll: while busy, the status bit changes value on each successive read, and it stops changing once the operation ends.

The write engine drives `busy` and keeps the last loaded byte on `last_data`. The array read path presents `array_data`. The host interface pulses `rd_stb` once for each read. The block registers the selected byte on that strobe and holds it until the next strobe. When no operation is in progress, the block passes array data through unchanged. The alternating bit moves only on read strobes and not with the clock. It starts from a defined value at the beginning of every new internal operation.

Top module: `wstat_responder`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` is 8'h00, and the alternating-bit state is 0.
- R2: A strobed read taken while `busy` is 1 returns bit 7 as the inverse of bit 7 of `last_data`.
- R3: A strobed read taken while `busy` is 1 returns bits 5..0 equal to bits 5..0 of `last_data`, including when `last_data` changes during the operation.
- R4: Successive strobed reads while `busy` is 1 return bit 6 with alternating values: the first read after `busy` rises returns 0, the next returns 1, and so on.
- R5: The alternating bit advances only on a strobed read taken while busy. Idle clock cycles between reads do not change the sequence.
- R6: A rising edge of `busy` returns the alternating bit to 0, whatever value the previous operation left it at.
- R7: A strobed read taken while `busy` is 0 returns `array_data` unchanged on all 8 bits.
- R8: `rd_data` takes the new value in the cycle after the clock edge that samples `rd_stb` high. It holds that value while `rd_stb` stays low, even when the inputs change.
- R9: A read strobe that arrives in the same cycle as the rising edge of `busy` returns bit 6 as 0, and the next busy read returns 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_stb | input | 1 | One-cycle pulse for each host read |
| busy | input | 1 | High while the write engine runs an internal write or erase |
| last_data | input | 8 | Last byte loaded before the internal operation |
| array_data | input | 8 | True data read from the array |
| rd_data | output | 8 | Registered read data returned to the host |

## Verification
The bench mixes reads issued back-to-back with reads separated by idle gaps. Comparing the two shows whether the alternating bit moves with the strobe or with the clock. Two busy periods run in sequence, and the first leaves the toggle state at 1. This separates a design that clears the toggle state at each start from one that carries it over. One read strobe is placed on the same cycle that busy rises, which checks the ordering between clearing and advancing. The last-loaded byte is changed in the middle of a busy period, and reads are taken before and after the busy period ends. These cases separate the status path from the array pass-through.

// File: rtl/wstat_pkg.sv
// Package: shared defaults for the write-status polling responder.
// Assumes: the polled bit and the alternating bit are distinct positions.
package wstat_pkg;
    localparam int unsigned DATA_W_DEF   = 8;
    localparam int unsigned POLL_BIT_DEF = 7;
    localparam int unsigned TOG_BIT_DEF  = 6;
    localparam logic        TOG_INIT     = 1'b0;
endpackage

// File: rtl/wstat_start_detect.sv
// Module: detects the first cycle of each internal operation (busy rising).
// Assumes: busy is synchronous to clk.
module wstat_start_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic start
);
    logic busy_q;

    // Remember busy from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // Start pulse on a 0-to-1 transition.
    always_comb start = busy & ~busy_q;
endmodule

// File: rtl/wstat_toggle.sv
// Module: alternating status bit that moves once per busy read strobe.
// Assumes: start clears the bit before any advance in the same cycle.
module wstat_toggle
    import wstat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic adv,
    output logic tog_cur
);
    logic tog_q;

    // Value presented this cycle: the initial value on a start, else the stored one.
    always_comb tog_cur = start ? TOG_INIT : tog_q;

    // Store the next value; invert only when a busy read is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)   tog_q <= TOG_INIT;
        else if (adv) tog_q <= ~tog_cur;
        else          tog_q <= tog_cur;
    end
endmodule

// File: rtl/wstat_data_mux.sv
// Module: builds the status byte while busy, or passes array data when idle.
// Assumes: POLL_BIT and TOG_BIT are different and below DATA_W.
module wstat_data_mux #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned POLL_BIT = 7,
    parameter int unsigned TOG_BIT  = 6
) (
    input  logic              busy,
    input  logic              tog,
    input  logic [DATA_W-1:0] last_data,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] sel_data
);
    logic [DATA_W-1:0] status_byte;

    // Put each bit of the status byte in place, one generate branch per bit.
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (b == POLL_BIT) begin : g_poll
            assign status_byte[b] = ~last_data[b];
        end else if (b == TOG_BIT) begin : g_tog
            assign status_byte[b] = tog;
        end else begin : g_pass
            assign status_byte[b] = last_data[b];
        end
    end

    // Choose the status byte or the array byte.
    always_comb sel_data = busy ? status_byte : array_data;
endmodule

// File: rtl/wstat_responder.sv
// Module: top of the write-status polling responder. It registers the
// selected byte on each read strobe and holds it between strobes.
// Assumes: rd_stb is a one-cycle pulse for each read, synchronous to clk.
module wstat_responder
    import wstat_pkg::*;
#(
    parameter int unsigned DATA_W   = DATA_W_DEF,
    parameter int unsigned POLL_BIT = POLL_BIT_DEF,
    parameter int unsigned TOG_BIT  = TOG_BIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              busy,
    input  logic [DATA_W-1:0] last_data,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);
    logic              start;
    logic              tog_cur;
    logic              busy_rd;
    logic [DATA_W-1:0] sel_data;
    logic [DATA_W-1:0] rd_data_q;

    // A read that moves the alternating bit.
    always_comb busy_rd = rd_stb & busy;

    wstat_start_detect u_start (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .start (start)
    );

    wstat_toggle u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .adv     (busy_rd),
        .tog_cur (tog_cur)
    );

    wstat_data_mux #(
        .DATA_W   (DATA_W),
        .POLL_BIT (POLL_BIT),
        .TOG_BIT  (TOG_BIT)
    ) u_mux (
        .busy       (busy),
        .tog        (tog_cur),
        .last_data  (last_data),
        .array_data (array_data),
        .sel_data   (sel_data)
    );

    // Capture the selected byte on a strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data_q <= '0;
        else if (rd_stb) rd_data_q <= sel_data;
    end

    assign rd_data = rd_data_q;
endmodule

// File: rtl/wstat_responder_chk.sv
// Module: property checker for wstat_responder, attached by bind below.
// Assumes: same parameters as the top it is bound to.
module wstat_responder_chk #(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned POLL_BIT = 7,
    parameter int unsigned TOG_BIT  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              busy,
    input logic [DATA_W-1:0] last_data,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] PASS_MASK =
        ~((DATA_W'(1) << POLL_BIT) | (DATA_W'(1) << TOG_BIT));

    logic busy_q;
    // Previous busy, tracked by the checker itself.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    // R2
    a_r2_poll_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> rd_data[POLL_BIT] == ~$past(last_data[POLL_BIT]));

    // R3
    a_r3_low_bits_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> (rd_data & PASS_MASK) == ($past(last_data) & PASS_MASK));

    // R7
    a_r7_idle_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !busy) |=> rd_data == $past(array_data));

    // R8
    a_r8_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    // R9
    a_r9_start_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy && !busy_q) |=> rd_data[TOG_BIT] == 1'b0);
endmodule

bind wstat_responder wstat_responder_chk #(
    .DATA_W   (DATA_W),
    .POLL_BIT (POLL_BIT),
    .TOG_BIT  (TOG_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_stb     (rd_stb),
    .busy       (busy),
    .last_data  (last_data),
    .array_data (array_data),
    .rd_data    (rd_data)
);

// File: tb/wstat_responder_bench.sv
// Bench: the driver pushes expected read bytes into a queue. A monitor pops
// them one cycle after each strobe and compares them with rd_data.
module wstat_responder_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_stb = 1'b0;
    logic       busy = 1'b0;
    logic [7:0] last_data = 8'h00;
    logic [7:0] array_data = 8'h00;
    logic [7:0] rd_data;

    int   n_run = 0;
    int   n_fail = 0;
    logic model_tog = 1'b0;
    logic pend = 1'b0;
    bit   done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wstat_responder u_wstat_responder (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb),
        .busy       (busy),
        .last_data  (last_data),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // Note that a strobe was sampled at this edge.
    always @(posedge clk) pend <= rd_stb;

    // Monitor: compare the result one edge after each sampled strobe.
    always @(negedge clk) begin
        if (pend && rst_n) begin
            if (exp_q.size() == 0) begin
                n_run++; n_fail++;
                $display("FAIL scoreboard: rd_data=%02h expected=none", rd_data);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // Driver: change busy at a negedge; a rising edge resets the model toggle (R6).
    task automatic set_busy(input logic b);
        if (b && !busy) model_tog = 1'b0;
        busy = b;
    endtask

    // Driver: one strobed read, with its expected byte computed from the requirements.
    task automatic do_read(input string tag);
        logic [7:0] e;
        if (busy) begin
            e = last_data;
            e[7] = ~last_data[7];
            e[6] = model_tog;
            model_tog = ~model_tog;
        end else begin
            e = array_data;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        #(CLK_PERIOD * 20000);
        n_run++; n_fail++;
        $display("FAIL watchdog: rd_data=%02h expected=finished", rd_data);
        finish_run();
    end

    initial begin
        logic [7:0] held;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", rd_data, 8'h00);

        // R7: idle reads pass array data.
        array_data = 8'h3C; do_read("R7 idle pass 3C");
        array_data = 8'hA5; do_read("R7 idle pass A5");
        idle(1);

        // R8: hold with no strobe while inputs change.
        held = rd_data;
        array_data = 8'h0F; last_data = 8'h77;
        idle(3);
        check("R8 hold without strobe", rd_data, held);

        // R2/R4: back-to-back busy reads, 0/1/0/1 on bit 6.
        last_data = 8'h5A; array_data = 8'h11;
        set_busy(1'b1); idle(1);
        do_read("R2 R4 busy read 1");
        do_read("R4 busy read 2");
        do_read("R4 busy read 3");
        do_read("R4 busy read 4");

        // R5: idle gap does not move the toggle.
        idle(6);
        do_read("R5 read after gap");

        // R3: last_data changes mid-operation.
        last_data = 8'hC3;
        do_read("R3 R2 new last byte");
        do_read("R3 second read");  // seven busy reads, toggle model now 1

        // R7 after completion.
        set_busy(1'b0); array_data = 8'hC3;
        do_read("R7 after completion");
        array_data = 8'h96; do_read("R7 idle read no toggle effect");

        // R6: new operation restarts at 0 after leaving the state at 1.
        last_data = 8'h24;
        set_busy(1'b1); idle(2);
        do_read("R6 restart read 1");
        do_read("R6 restart read 2");
        do_read("R6 restart read 3");  // odd count, leaves toggle at 1

        // R9: strobe on the same cycle busy rises.
        set_busy(1'b0); idle(2);
        last_data = 8'h81;
        set_busy(1'b1);
        do_read("R9 strobe with busy rise");
        do_read("R9 following read");
        idle(2);
        set_busy(1'b0);
        do_read("R7 final idle");
        idle(3);
        if (exp_q.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL scoreboard: leftover=%0d expected=0", exp_q.size());
        end
        finish_run();
    end
endmodule